// File: doc/BRIEF.md
# Deferred-Exception Poison Tracker

This block holds a small architectural register file and one poison flag per register. It lets a core run instructions ahead of a resolved branch without having to undo their side effects. The core presents one retiring instruction per cycle. With it come a speculative marker, up to two source register indices (each with its own valid bit), an optional destination, the result value and a flag that says whether the instruction hit a terminating exception.

A speculative instruction that faults does not signal anything. Its destination is marked as poisoned instead. Poison then flows to the destination of any later speculative instruction that reads a poisoned register. A non-speculative instruction that reads a poisoned register raises a fault naming the offending source. A non-speculative instruction that itself raises an exception has that exception reported at once.

The register file's combinational read ports give the core its operand values, along with the raw poison state of the two selected registers.

Top module: `poison_tracker`

## Requirements
- R1: After reset every register reads zero with its poison flag clear, and `excValid` and `faultValid` are low.
- R2: An accepted non-speculative instruction with no poisoned valid source and `excRaised` low writes `resultData` to its destination and clears that destination's poison flag. Both are visible on the read ports from the cycle after the accepting edge.
- R3: An accepted speculative instruction with `excRaised` high sets its destination's poison flag and leaves the destination's data unchanged. It raises neither `excValid` nor `faultValid`.
- R4: An accepted speculative instruction that reads a poisoned register through a valid source sets its destination's poison flag and leaves the data unchanged. It raises no output.
- R5: An accepted non-speculative instruction that reads a poisoned register through a valid source pulses `faultValid` with `faultIdx` equal to that source's index. `excValid` stays low even if `excRaised` is high. The destination's data and poison flag are left unchanged.
- R6: When both valid sources of a faulting instruction are poisoned, `faultIdx` is the lower of the two indices.
- R7: An accepted non-speculative instruction with `excRaised` high and no poisoned valid source pulses `excValid`. It leaves its destination's data and poison flag unchanged.
- R8: An accepted speculative instruction with `excRaised` low and no poisoned valid source writes `resultData` to its destination and clears that destination's poison flag.
- R9: Register 0 always reads zero and is never poisoned; writes and poison updates aimed at it have no effect.
- R10: `excValid`, `faultValid` and `faultIdx` are registered. They follow the instruction accepted at the previous rising edge, so each is a one-cycle pulse. A cycle with `instValid` low changes no register and leaves both flags low in the following cycle.
- R11: A source whose valid bit is low is ignored, even when its index names a poisoned register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is presented this cycle |
| instSpec | input | 1 | The instruction was executed speculatively |
| srcAValid | input | 1 | Source A is read by the instruction |
| srcAIdx | input | 4 | Source A register index |
| srcBValid | input | 1 | Source B is read by the instruction |
| srcBIdx | input | 4 | Source B register index |
| dstValid | input | 1 | The instruction has a destination |
| dstIdx | input | 4 | Destination register index |
| resultData | input | 32 | Result value for the destination |
| excRaised | input | 1 | The instruction raised a terminating exception |
| srcAData | output | 32 | Contents of register `srcAIdx` |
| srcAPoison | output | 1 | Poison flag of register `srcAIdx` |
| srcBData | output | 32 | Contents of register `srcBIdx` |
| srcBPoison | output | 1 | Poison flag of register `srcBIdx` |
| excValid | output | 1 | Immediate exception of the previous accepted instruction |
| faultValid | output | 1 | Deferred fault of the previous accepted instruction |
| faultIdx | output | 4 | Source register that caused the fault |

## Verification
The assertions assume that every control input is a known value at each rising edge once reset is released. They also assume that register indices always fall inside the register file, which holds because the file size is a power of two and fills the index width. The stimulus drives all inputs from tasks on the falling edge, so nothing is ever left undriven. Indices are drawn as random values modulo the register count. Speculative, exception and source-valid bits are biased so that poison builds up, spreads and is cleared again many times during the run.

// File: rtl/poison_pkg.sv
package poison_pkg;

  // Strobes from the decision logic to the register state
  typedef struct packed {
    logic wrData;     // write resultData into the destination
    logic setPoison;  // mark the destination poisoned
    logic clrPoison;  // clear the destination poison flag
    logic raiseFault; // deferred fault this cycle
    logic raiseExc;   // immediate exception this cycle
    logic faultSelB;  // fault reports source B rather than source A
  } ctrlStrb_t;

endpackage

// File: rtl/poison_ctrl.sv
module poison_ctrl
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic             instSpec,
  input  logic             excRaised,
  input  logic             dstValid,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic             usePoisA,  // valid source A that is poisoned
  input  logic             usePoisB,  // valid source B that is poisoned
  output ctrlStrb_t        strb,
  output logic             excValid,
  output logic             faultValid
);

  logic anyPois;
  assign anyPois = usePoisA | usePoisB;

  always_comb begin
    strb = '0;
    if (instValid) begin
      if (instSpec) begin
        if (excRaised || anyPois) begin
          strb.setPoison = dstValid;
        end else begin
          strb.wrData    = dstValid;
          strb.clrPoison = dstValid;
        end
      end else if (anyPois) begin
        strb.raiseFault = 1'b1;
        strb.faultSelB  = !usePoisA || (usePoisB && (srcBIdx < srcAIdx));
      end else if (excRaised) begin
        strb.raiseExc = 1'b1;
      end else begin
        strb.wrData    = dstValid;
        strb.clrPoison = dstValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid   <= 1'b0;
      faultValid <= 1'b0;
    end else begin
      excValid   <= strb.raiseExc;
      faultValid <= strb.raiseFault;
    end
  end

  // R5: fault and immediate exception never coexist
  assert_fault_exc_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(faultValid && excValid));

  // R5: a committed read of a poisoned source produces a fault next cycle
  assert_fault_on_use_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instSpec && anyPois) |=> (faultValid && !excValid));

  // R7: clean committed exception reported immediately
  assert_exc_now_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instSpec && !anyPois && excRaised) |=> excValid);

  // R3: speculative instructions never signal anything
  assert_spec_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instSpec) |=> (!excValid && !faultValid));

  // R10: idle cycle leaves both flags low
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> (!excValid && !faultValid));

endmodule

// File: rtl/poison_datapath.sv
module poison_datapath
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              srcAValid,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic              srcBValid,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] resultData,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcAPoison,
  output logic [DATA_W-1:0] srcBData,
  output logic              srcBPoison,
  output logic              usePoisA,
  output logic              usePoisB,
  output logic [IDX_W-1:0]  faultIdx
);

  logic [DATA_W-1:0]   regQ [NUM_REGS];
  logic [NUM_REGS-1:0] poisQ;
  logic                dstLive;

  assign dstLive = (dstIdx != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
      poisQ <= '0;
    end else if (dstLive) begin
      if (strb.wrData) regQ[dstIdx] <= resultData;
      if (strb.setPoison)      poisQ[dstIdx] <= 1'b1;
      else if (strb.clrPoison) poisQ[dstIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                faultIdx <= '0;
    else if (strb.raiseFault) faultIdx <= strb.faultSelB ? srcBIdx : srcAIdx;
  end

  assign srcAData   = regQ[srcAIdx];
  assign srcBData   = regQ[srcBIdx];
  assign srcAPoison = poisQ[srcAIdx];
  assign srcBPoison = poisQ[srcBIdx];
  assign usePoisA   = srcAValid & poisQ[srcAIdx];
  assign usePoisB   = srcBValid & poisQ[srcBIdx];

  // R3: a poison strobe to a live register marks it
  assert_poison_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setPoison && dstLive) |=> poisQ[$past(dstIdx)]);

  // R2: a data strobe lands the value in the named register
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && dstLive) |=> (regQ[$past(dstIdx)] == $past(resultData)));

  // R5: a fault cycle leaves the destination untouched
  assert_fault_keeps_dst_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.raiseFault && dstLive) |=>
      (regQ[$past(dstIdx)] == $past(regQ[dstIdx]) &&
       poisQ[$past(dstIdx)] == $past(poisQ[dstIdx])));

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic              instSpec,
  input  logic              srcAValid,
  input  logic [IDX_W-1:0]  srcAIdx,
  input  logic              srcBValid,
  input  logic [IDX_W-1:0]  srcBIdx,
  input  logic              dstValid,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [DATA_W-1:0] resultData,
  input  logic              excRaised,
  output logic [DATA_W-1:0] srcAData,
  output logic              srcAPoison,
  output logic [DATA_W-1:0] srcBData,
  output logic              srcBPoison,
  output logic              excValid,
  output logic              faultValid,
  output logic [IDX_W-1:0]  faultIdx
);

  ctrlStrb_t strb;
  logic      usePoisA;
  logic      usePoisB;

  poison_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instSpec(instSpec),
    .excRaised(excRaised), .dstValid(dstValid), .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx), .usePoisA(usePoisA), .usePoisB(usePoisB),
    .strb(strb), .excValid(excValid), .faultValid(faultValid)
  );

  poison_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .srcAValid(srcAValid),
    .srcAIdx(srcAIdx), .srcBValid(srcBValid), .srcBIdx(srcBIdx),
    .dstIdx(dstIdx), .resultData(resultData), .srcAData(srcAData),
    .srcAPoison(srcAPoison), .srcBData(srcBData), .srcBPoison(srcBPoison),
    .usePoisA(usePoisA), .usePoisB(usePoisB), .faultIdx(faultIdx)
  );

  // R9: register 0 always reads as clean zero
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rstN)
    (srcAIdx == '0) |-> (srcAData == '0 && !srcAPoison));

endmodule

// File: tb/tb_poison_tracker.sv
module tb_poison_tracker;
  localparam int NR = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          instValid, instSpec, srcAValid, srcBValid, dstValid, excRaised;
  logic [3:0]    srcAIdx, srcBIdx, dstIdx;
  logic [DW-1:0] resultData;
  logic [DW-1:0] srcAData, srcBData;
  logic          srcAPoison, srcBPoison, excValid, faultValid;
  logic [3:0]    faultIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [DW-1:0] mReg [NR];
  logic          mPois [NR];

  always #5 clk = ~clk;

  poison_tracker dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instSpec(instSpec),
    .srcAValid(srcAValid), .srcAIdx(srcAIdx), .srcBValid(srcBValid),
    .srcBIdx(srcBIdx), .dstValid(dstValid), .dstIdx(dstIdx),
    .resultData(resultData), .excRaised(excRaised), .srcAData(srcAData),
    .srcAPoison(srcAPoison), .srcBData(srcBData), .srcBPoison(srcBPoison),
    .excValid(excValid), .faultValid(faultValid), .faultIdx(faultIdx)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected outcome of one instruction, from the requirements
  function automatic void predict(
      input logic v, sp, sav, input logic [3:0] sa, input logic sbv, input logic [3:0] sb,
      input logic dv, input logic [3:0] d, input logic [DW-1:0] data, input logic ex,
      output logic eExc, output logic eFault, output logic [3:0] eIdx);
    logic pa, pb;
    pa = sav && mPois[sa];                       // R11
    pb = sbv && mPois[sb];
    eExc = 0; eFault = 0; eIdx = 0;
    if (!v) return;                              // R10
    if (sp) begin
      if (ex || pa || pb) begin                  // R3, R4
        if (dv && d != 0) mPois[d] = 1;
      end else if (dv && d != 0) begin           // R8
        mReg[d] = data; mPois[d] = 0;
      end
    end else if (pa || pb) begin                 // R5, R6
      eFault = 1;
      if (pa && pb) eIdx = (sa < sb) ? sa : sb;
      else          eIdx = pa ? sa : sb;
    end else if (ex) begin                       // R7
      eExc = 1;
    end else if (dv && d != 0) begin             // R2, R9
      mReg[d] = data; mPois[d] = 0;
    end
  endfunction

  task automatic apply(input string tag, input logic v, sp, sav, input logic [3:0] sa,
      input logic sbv, input logic [3:0] sb, input logic dv, input logic [3:0] d,
      input logic [DW-1:0] data, input logic ex);
    logic eExc, eFault;
    logic [3:0] eIdx;
    @(negedge clk);
    instValid = v; instSpec = sp; srcAValid = sav; srcAIdx = sa; srcBValid = sbv;
    srcBIdx = sb; dstValid = dv; dstIdx = d; resultData = data; excRaised = ex;
    #1;
    check({tag, " srcAData"}, srcAData, mReg[sa]);
    check({tag, " srcBPoison"}, {31'b0, srcBPoison}, {31'b0, mPois[sb]});
    predict(v, sp, sav, sa, sbv, sb, dv, d, data, ex, eExc, eFault, eIdx);
    @(posedge clk); #1;
    check({tag, " excValid"}, {31'b0, excValid}, {31'b0, eExc});
    check({tag, " faultValid"}, {31'b0, faultValid}, {31'b0, eFault});
    if (eFault) check({tag, " faultIdx"}, {28'b0, faultIdx}, {28'b0, eIdx});
  endtask

  task automatic peek(input string tag, input logic [3:0] r);
    apply(tag, 0, 0, 0, r, 0, r, 0, 0, 32'hDEAD_BEEF, 0);
    check({tag, " poisonA"}, {31'b0, srcAPoison}, {31'b0, mPois[r]});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) begin mReg[i] = '0; mPois[i] = 0; end
    rstN = 0; instValid = 0; instSpec = 0; srcAValid = 0; srcBValid = 0;
    dstValid = 0; excRaised = 0; srcAIdx = 0; srcBIdx = 0; dstIdx = 0; resultData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    check("R1 excValid", {31'b0, excValid}, 32'd0);
    check("R1 faultValid", {31'b0, faultValid}, 32'd0);
    for (int r = 0; r < NR; r++) peek("R1 reset", r[3:0]);

    apply("R2 commit write", 1, 0, 0, 0, 0, 0, 1, 4'd3, 32'h0000_00A5, 0);
    peek("R2 readback", 4'd3);
    apply("R3 spec exc", 1, 1, 1, 4'd3, 0, 0, 1, 4'd5, 32'h1111_1111, 1);
    peek("R3 poisoned", 4'd5);
    apply("R3 spec exc r3", 1, 1, 0, 0, 0, 0, 1, 4'd3, 32'h2222_2222, 1);
    peek("R3 data kept", 4'd3);
    apply("R4 propagate", 1, 1, 0, 4'd1, 1, 4'd5, 1, 4'd6, 32'h3333_3333, 0);
    peek("R4 dst poisoned", 4'd6);
    apply("R5 fault on B", 1, 0, 1, 4'd2, 1, 4'd6, 1, 4'd7, 32'h4444_4444, 1);
    peek("R5 dst untouched", 4'd7);
    apply("R6 both poisoned", 1, 0, 1, 4'd6, 1, 4'd5, 1, 4'd8, 32'h5555_5555, 0);
    apply("R6 both poisoned swap", 1, 0, 1, 4'd3, 1, 4'd6, 0, 0, 32'h0, 0);
    apply("R7 commit exc", 1, 0, 1, 4'd2, 0, 4'd5, 1, 4'd9, 32'h6666_6666, 1);
    peek("R7 dst untouched", 4'd9);
    apply("R8 spec clean", 1, 1, 1, 4'd2, 0, 4'd6, 1, 4'd5, 32'h7777_7777, 0);
    peek("R8 cleared", 4'd5);
    apply("R9 write r0", 1, 0, 0, 0, 0, 0, 1, 4'd0, 32'hFFFF_FFFF, 0);
    apply("R9 poison r0", 1, 1, 0, 0, 0, 0, 1, 4'd0, 32'hFFFF_FFFF, 1);
    peek("R9 r0 clean", 4'd0);
    apply("R11 invalid source", 1, 0, 0, 4'd6, 0, 4'd3, 1, 4'd10, 32'h8888_8888, 0);
    peek("R11 written", 4'd10);
    apply("R10 idle", 0, 0, 1, 4'd6, 1, 4'd3, 1, 4'd11, 32'h9999_9999, 1);
    peek("R10 no change", 4'd11);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      apply("R2-random", rv[0] | rv[1] | rv[2], rv[3], rv[4] | rv[5], rv[9:6],
            rv[10], rv[14:11], rv[15] | rv[16], rv[20:17], $urandom,
            rv[21] & rv[22]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule